// File: doc/BRIEF.md
# NMEA Sentence Receiver and Field Splitter

This block takes the raw asynchronous serial line from a position receiver, recovers 8N1 characters, and cuts the character stream into comma-separated ASCII sentences. Each payload character leaves the block on a byte strobe tagged with the index of the field it belongs to. Each comma or the closing CR LF produces a field-end strobe that carries the index of the field just closed. The closing CR LF also raises a sentence-done pulse. Downstream logic can therefore pick fields by position and never has to scan for delimiters itself.

The line is oversampled sixteen times per bit and each bit is taken at its centre. The bit rate is set by a clock-divider parameter, which gives 4800 bit/s from the system clock. A sentence opens on '$'. Empty fields between adjacent commas still advance the field index, so field positions stay correct when a receiver leaves a value blank. Framing faults, over-long sentences, non-ASCII bytes and malformed line endings pulse an error output and discard the sentence in progress.

Top module: `nmea_splitter`

## Requirements
- R1: After reset, byte_valid_o, field_end_o, sentence_done_o and err_o are all 0.
- R2: Characters are received as one low start bit, 8 data bits LSB first and one stop bit. Each bit lasts 16*CLK_DIV clocks and is sampled near its centre. Every byte value is recovered exactly.
- R3: A '$' (0x24) opens a sentence with field index 0. The '$' itself is never emitted, and characters received outside a sentence produce no output.
- R4: Inside a sentence, every character other than '$', ',', CR (0x0D), LF (0x0A) or a byte with bit 7 set is emitted once on byte_o with byte_valid_o, and field_o holds the current field index.
- R5: A ',' (0x2C) pulses field_end_o with field_o equal to the field being closed, then advances the index by one. Adjacent commas give a field-end with no bytes, and no index is skipped.
- R6: CR followed directly by LF closes the sentence. field_end_o for the last field and sentence_done_o pulse in the same cycle.
- R7: The field index saturates at 31. Bytes and field-ends beyond field 31 are all tagged 31.
- R8: A sentence may hold at most 82 characters, counting '$', CR and LF. The 83rd character pulses err_o and discards the sentence without emitting that character.
- R9: A character whose stop bit is low pulses err_o, whether or not a sentence is open, and discards any open sentence. The receiver then waits for the line to return high before looking for a new start bit.
- R10: A '$' inside an open sentence restarts it at field index 0 without pulsing err_o.
- R11: Inside a sentence, a byte with bit 7 set, a CR not followed by LF, or an LF not preceded by CR pulses err_o and discards the sentence.
- R12: After a discard, nothing is emitted until the next '$'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| byte_o | output | 8 | Field character |
| byte_valid_o | output | 1 | byte_o carries a new field character |
| field_o | output | FW (5) | Field index for byte or field-end |
| field_end_o | output | 1 | The field in field_o has ended |
| sentence_done_o | output | 1 | A sentence closed correctly with CR LF |
| err_o | output | 1 | Framing, length or content error; sentence dropped |

## Verification
The bench builds the block with CLK_DIV = 1, so one bit lasts 16 clocks and a full character takes 160 clocks. At that rate the bench can send every printable code and sweep comma counts on both sides of the field-index limit of 31. It can also send sentences of exactly 82 and 83 characters, all within the run budget. The sweep uses a mix of empty and filled fields. Expected event sequences are derived per character from the framing rules and compared in order against what the block emits.

// File: rtl/nmea_pkg.sv
package nmea_pkg;
  localparam logic [7:0] CH_DOLLAR = 8'h24;
  localparam logic [7:0] CH_COMMA  = 8'h2C;
  localparam logic [7:0] CH_CR     = 8'h0D;
  localparam logic [7:0] CH_LF     = 8'h0A;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT
  } rx_state_e;
endpackage

// File: rtl/nmea_uart_rx.sv
module nmea_uart_rx
  import nmea_pkg::*;
#(
  parameter int CLK_DIV = 1628
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       ferr_o
);
  localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_DIV - 1);

  logic [1:0]    sync_q;
  logic          line;
  rx_state_e     st_q, st_d;
  logic [PW-1:0] pre_q, pre_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          valid_q, valid_d, ferr_q, ferr_d;
  logic          tick;

  assign line = sync_q[1];
  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    st_d    = st_q;
    pre_d   = (tick) ? '0 : pre_q + 1'b1;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    case (st_q)
      RX_IDLE: begin
        pre_d = '0;
        cnt_d = '0;
        if (!line) st_d = RX_START;
      end
      RX_START: if (tick) begin
        if (cnt_q == 4'd7) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = (!line) ? RX_DATA : RX_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RX_DATA: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == 4'd15) begin
          sh_d  = {line, sh_q[7:1]};
          bit_d = bit_q + 1'b1;
          if (bit_q == 3'd7) st_d = RX_STOP;
        end
      end
      RX_STOP: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == 4'd15) begin
          if (line) begin
            valid_d = 1'b1;
            st_d    = RX_IDLE;
          end else begin
            ferr_d = 1'b1;
            st_d   = RX_WAIT;
          end
        end
      end
      RX_WAIT: if (line) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      st_q    <= RX_IDLE;
      pre_q   <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rxd_i};
      st_q    <= st_d;
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = sh_q;
  assign ferr_o  = ferr_q;

  // R2: a received byte only follows the stop-bit phase
  p_valid_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(st_q == RX_STOP));
  // R9: a framing fault leaves the receiver waiting for an idle line
  p_ferr_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q |-> (st_q == RX_WAIT));
endmodule

// File: rtl/nmea_framer.sv
module nmea_framer
  import nmea_pkg::*;
#(
  parameter int MAX_LEN   = 82,
  parameter int MAX_FIELD = 31,
  parameter int FW        = $clog2(MAX_FIELD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_ferr,
  output logic [7:0]    byte_o,
  output logic          byte_valid_o,
  output logic [FW-1:0] field_o,
  output logic          field_end_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int LW = $clog2(MAX_LEN + 2);
  localparam logic [LW-1:0] LEN_MAX = LW'(MAX_LEN);
  localparam logic [FW-1:0] FLD_MAX = FW'(MAX_FIELD);

  logic          act_q, act_d, cr_q, cr_d;
  logic [FW-1:0] fld_q, fld_d;
  logic [LW-1:0] len_q, len_d;
  logic [7:0]    byte_q, byte_d;
  logic [FW-1:0] fout_q, fout_d;
  logic          bv_q, bv_d, fe_q, fe_d, done_q, done_d, err_q, err_d;

  always_comb begin
    act_d  = act_q;
    cr_d   = cr_q;
    fld_d  = fld_q;
    len_d  = len_q;
    byte_d = byte_q;
    fout_d = fout_q;
    bv_d   = 1'b0;
    fe_d   = 1'b0;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (in_ferr) begin
      err_d = 1'b1;
      act_d = 1'b0;
    end else if (in_valid) begin
      if (in_data == CH_DOLLAR) begin
        act_d = 1'b1;
        cr_d  = 1'b0;
        fld_d = '0;
        len_d = LW'(1);
      end else if (act_q) begin
        if (len_q >= LEN_MAX) begin
          err_d = 1'b1;
          act_d = 1'b0;
        end else begin
          len_d = len_q + 1'b1;
          if (in_data[7]) begin
            err_d = 1'b1;
            act_d = 1'b0;
          end else if (cr_q) begin
            act_d = 1'b0;
            if (in_data == CH_LF) begin
              fe_d   = 1'b1;
              done_d = 1'b1;
              fout_d = fld_q;
            end else begin
              err_d = 1'b1;
            end
          end else if (in_data == CH_CR) begin
            cr_d = 1'b1;
          end else if (in_data == CH_LF) begin
            err_d = 1'b1;
            act_d = 1'b0;
          end else if (in_data == CH_COMMA) begin
            fe_d   = 1'b1;
            fout_d = fld_q;
            if (fld_q != FLD_MAX) fld_d = fld_q + 1'b1;
          end else begin
            bv_d   = 1'b1;
            byte_d = in_data;
            fout_d = fld_q;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cr_q   <= 1'b0;
      fld_q  <= '0;
      len_q  <= '0;
      byte_q <= '0;
      fout_q <= '0;
      bv_q   <= 1'b0;
      fe_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      cr_q   <= cr_d;
      fld_q  <= fld_d;
      len_q  <= len_d;
      byte_q <= byte_d;
      fout_q <= fout_d;
      bv_q   <= bv_d;
      fe_q   <= fe_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign byte_o       = byte_q;
  assign byte_valid_o = bv_q;
  assign field_o      = fout_q;
  assign field_end_o  = fe_q;
  assign done_o       = done_q;
  assign err_o        = err_q;

  // R8: an open sentence never holds more than MAX_LEN characters
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (len_q <= LEN_MAX));
  // R7: once at the limit the index stays there until a restart or close
  p_field_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && fld_q == FLD_MAX) |=>
      (fld_q == FLD_MAX || !act_q || $past(in_valid && !in_ferr && in_data == CH_DOLLAR)));
  // R10: '$' always reopens at field 0 with no error
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ferr && in_data == CH_DOLLAR) |=> (act_q && fld_q == '0 && !err_q));
  // R9: a framing fault closes the sentence and flags it
  p_ferr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ferr |=> (!act_q && err_q));
  // R4: byte, field-end and error strobes never coincide
  p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bv_q, fe_q, err_q}));
endmodule

// File: rtl/nmea_splitter.sv
module nmea_splitter #(
  parameter int CLK_DIV   = 1628,
  parameter int MAX_LEN   = 82,
  parameter int MAX_FIELD = 31,
  parameter int FW        = $clog2(MAX_FIELD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd_i,
  output logic [7:0]    byte_o,
  output logic          byte_valid_o,
  output logic [FW-1:0] field_o,
  output logic          field_end_o,
  output logic          sentence_done_o,
  output logic          err_o
);
  logic [1:0] rst_sq;
  logic       rst_n_int;
  logic       rx_valid, rx_ferr;
  logic [7:0] rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_n_int = rst_sq[1];

  nmea_uart_rx #(.CLK_DIV(CLK_DIV)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rxd_i   (rxd_i),
    .valid_o (rx_valid),
    .data_o  (rx_data),
    .ferr_o  (rx_ferr)
  );

  nmea_framer #(.MAX_LEN(MAX_LEN), .MAX_FIELD(MAX_FIELD), .FW(FW)) u_frm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .in_valid     (rx_valid),
    .in_data      (rx_data),
    .in_ferr      (rx_ferr),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .field_o      (field_o),
    .field_end_o  (field_end_o),
    .done_o       (sentence_done_o),
    .err_o        (err_o)
  );
endmodule

// File: tb/sim_nmea_splitter.sv
module sim_nmea_splitter;
  localparam int DIV = 1;
  localparam int BITC = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] byte_o;
  logic       bv, fe, done, err;
  logic [4:0] fld;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [15:0] act_log [0:255];
  logic [15:0] exp_log [0:255];
  int n_act = 0;
  int n_exp = 0;

  bit       m_act = 0, m_cr = 0;
  int       m_fld = 0, m_len = 0;

  always #4 clk = ~clk;

  nmea_splitter #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd),
    .byte_o(byte_o), .byte_valid_o(bv), .field_o(fld),
    .field_end_o(fe), .sentence_done_o(done), .err_o(err)
  );

  // event kinds: 1 byte, 2 field end, 3 done, 4 error
  always @(negedge clk) begin
    if (rst_n) begin
      if (bv   && n_act < 256) begin act_log[n_act] = {3'd1, fld, byte_o}; n_act++; end
      if (fe   && n_act < 256) begin act_log[n_act] = {3'd2, fld, 8'h00};  n_act++; end
      if (done && n_act < 256) begin act_log[n_act] = {3'd3, 5'd0, 8'h00}; n_act++; end
      if (err  && n_act < 256) begin act_log[n_act] = {3'd4, 5'd0, 8'h00}; n_act++; end
    end
  end

  task automatic push(input logic [2:0] k, input int f, input logic [7:0] b);
    if (n_exp < 256) begin
      exp_log[n_exp] = {k, 5'(f), b};
      n_exp++;
    end
  endtask

  task automatic drop_err();
    push(3'd4, 0, 8'h00);
    m_act = 0;
  endtask

  // expected events per character, taken from the requirements
  task automatic model(input logic [7:0] c, input bit bad);
    if (bad) drop_err();
    else if (c == 8'h24) begin m_act = 1; m_cr = 0; m_fld = 0; m_len = 1; end
    else if (m_act) begin
      if (m_len >= 82) drop_err();
      else begin
        m_len++;
        if (c[7]) drop_err();
        else if (m_cr) begin
          if (c == 8'h0A) begin push(3'd2, m_fld, 8'h00); push(3'd3, 0, 8'h00); m_act = 0; end
          else drop_err();
        end
        else if (c == 8'h0D) m_cr = 1;
        else if (c == 8'h0A) drop_err();
        else if (c == 8'h2C) begin
          push(3'd2, m_fld, 8'h00);
          if (m_fld < 31) m_fld++;
        end
        else push(3'd1, m_fld, c);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] c, input bit bad);
    @(negedge clk) rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = c[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = bad ? 1'b0 : 1'b1;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
    if (bad) repeat (2 * BITC) @(negedge clk);
    model(c, bad);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i], 1'b0);
  endtask

  task automatic crlf();
    send_byte(8'h0D, 1'b0);
    send_byte(8'h0A, 1'b0);
  endtask

  task automatic begin_scn();
    n_act = 0;
    n_exp = 0;
  endtask

  task automatic end_scn(input string req, input string name);
    int bad_i;
    repeat (3 * BITC) @(negedge clk);
    n_tests++;
    bad_i = -1;
    if (n_act != n_exp) begin
      n_fail++;
      $display("FAIL %s %s: event count actual %0d expected %0d", req, name, n_act, n_exp);
    end else begin
      for (int i = 0; i < n_act; i++)
        if (bad_i < 0 && act_log[i] != exp_log[i]) bad_i = i;
      if (bad_i >= 0) begin
        n_fail++;
        $display("FAIL %s %s: event %0d actual %h expected %h", req, name, bad_i,
                 act_log[bad_i], exp_log[bad_i]);
      end
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    string s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet outputs after reset
    n_tests++;
    if ({bv, fe, done, err} != 4'b0000) begin
      n_fail++;
      $display("FAIL R1: strobes actual %b expected 0000", {bv, fe, done, err});
    end

    // R3 R4 R5 R6: basic sentence with an empty field
    begin_scn(); send_str("$GPGGA,12,,A"); crlf(); end_scn("R4", "basic sentence");

    // R3: noise before the opening '$' is ignored
    begin_scn(); send_str("xy,"); crlf(); send_str("$AB,C"); crlf();
    end_scn("R3", "leading noise");

    // R5 R7: comma sweep with empty and filled fields around the index limit
    for (int n = 0; n <= 33; n++) begin
      if (n > 8 && n < 30) continue;
      begin_scn();
      s = "$P";
      for (int k = 1; k <= n; k++) s = {s, (k % 3 == 0) ? "," : ",z"};
      send_str(s); crlf();
      end_scn((n >= 31) ? "R7" : "R5", $sformatf("commas=%0d", n));
    end

    // R8: 82 characters accepted, 83 rejected, 92 rejected and recovered
    begin_scn(); s = "$"; for (int i = 0; i < 79; i++) s = {s, "b"};
    send_str(s); crlf(); end_scn("R8", "length 82");
    begin_scn(); s = "$"; for (int i = 0; i < 80; i++) s = {s, "c"};
    send_str(s); crlf(); end_scn("R8", "length 83");
    begin_scn(); s = "$"; for (int i = 0; i < 89; i++) s = {s, "a"};
    send_str(s); crlf(); send_str("$Q"); crlf(); end_scn("R12", "overlong then recover");

    // R9: bad stop bit inside and outside a sentence
    begin_scn(); send_str("$AB,C"); send_byte("D", 1'b1); send_str("E"); crlf();
    end_scn("R9", "framing mid sentence");
    begin_scn(); send_byte(8'h55, 1'b1); send_str("$K"); crlf();
    end_scn("R9", "framing idle");

    // R10: restart on '$'
    begin_scn(); send_str("$AB,CD$EF,G"); crlf(); end_scn("R10", "restart");

    // R11: malformed content
    begin_scn(); send_str("$AB"); send_byte(8'hC1, 1'b0); send_str("Z"); crlf();
    end_scn("R11", "non-ascii");
    begin_scn(); send_str("$AB"); send_byte(8'h0D, 1'b0); send_str("x"); crlf();
    end_scn("R11", "cr without lf");
    begin_scn(); send_str("$AB"); send_byte(8'h0A, 1'b0); send_str("y"); crlf();
    end_scn("R11", "lf without cr");

    // R2: every printable code except the delimiters
    begin_scn(); send_byte(8'h24, 1'b0);
    for (int c = 8'h20; c < 8'h50; c++) if (c != 8'h24 && c != 8'h2C) send_byte(8'(c), 1'b0);
    crlf(); end_scn("R2", "printable low");
    begin_scn(); send_byte(8'h24, 1'b0);
    for (int c = 8'h50; c < 8'h7F; c++) send_byte(8'(c), 1'b0);
    crlf(); end_scn("R2", "printable high");

    finish_run();
  end
endmodule